// File: doc/BRIEF.md
# Coherent Byte-Access 16-bit Register

This block holds a 16-bit value that a byte-wide bus reaches one byte lane at a time. Other logic supplies a 16-bit live value for the bus to read. The block also drives a 16-bit committed value that other logic uses. Without care, a two-access read could mix bytes from two different live values, and a two-access write could expose a half-updated committed value. This block prevents both.

On the read path, the first byte read takes a snapshot of the whole live value. The bytes that follow come from that snapshot until every lane has been read. On the write path, each byte goes into a staging buffer. The committed register loads all staged bytes together once every lane has been written. The read path and the write path track their progress separately, and either lane may come first. Read data is combinational: it is valid in the same cycle as the read strobe. A read and a write in the same cycle is not allowed.

Top module: `coherent_reg16`

## Requirements
- R1: A read of either lane (bus_addr 0 selects bits 7:0, bus_addr 1 selects bits 15:8) with no snapshot pending returns that lane of live_val in the same cycle. It also captures all 16 bits of live_val as a snapshot. bus_rdata is zero when bus_rd is low.
- R2: While a snapshot is pending, reads return bytes from the snapshot, and changes on live_val are not visible on bus_rdata.
- R3: The snapshot is released in the cycle that the last unread lane is read. The next read after that captures a fresh snapshot.
- R4: Reading a lane that was already read, while the snapshot is pending, returns the snapshot byte again and keeps the snapshot pending.
- R5: Writing a byte stages it and leaves reg_val unchanged until every lane has been written.
- R6: When the last unwritten lane is written, reg_val takes all staged bytes at once, one clock edge after that write.
- R7: Both paths accept the lanes in either order. Read progress and write progress are tracked independently, so reads between writes do not disturb a staged write.
- R8: Writing the same lane again before the other lane is written replaces the staged byte and does not cause a commit.
- R9: After a synchronous active-low reset, reg_val is zero, no read snapshot is pending and no staged write remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Lane select: 0 low byte, 1 high byte |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while bus_rd is high |
| live_val | input | 16 | Value supplied by the surrounding logic |
| reg_val | output | 16 | Committed value |

## Verification
Reads run low-first and high-first, and live_val changes between the two accesses. A torn result and a coherent snapshot therefore give different bytes. Repeated reads of one lane separate "already read" from "pair complete". Repeated writes to one lane separate overwrite from commit. Reads placed between the two writes of a pair, and a reset in the middle of a pair, show whether the two paths are independent and whether reset clears both trackers.

// File: rtl/ccr_pkg.sv
// Package: shared types for the coherent byte-access register.
// Assumes: nothing beyond standard SystemVerilog.
package ccr_pkg;

    // Read snapshot state: open means the next read captures live data.
    typedef enum logic {
        SNAP_OPEN = 1'b0,
        SNAP_HELD = 1'b1
    } snap_state_e;

    // Lane count for a given word and byte width.
    function automatic int lane_count(input int data_w, input int byte_w);
        return data_w / byte_w;
    endfunction

endpackage

// File: rtl/ccr_read_latch.sv
// Module: read snapshot path. The first read of a set captures the whole
// live word. Reads return snapshot bytes until every lane has been read.
// Assumes: DATA_W is a multiple of BYTE_W, and rd and wr are never
// asserted in the same cycle (checked elsewhere).
module ccr_read_latch
    import ccr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int LANES = lane_count(DATA_W, BYTE_W),
    localparam int AW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] live,
    output logic [BYTE_W-1:0] rdata,
    output logic [DATA_W-1:0] snap_o,
    output logic              pend_o
);

    snap_state_e              state_q;
    logic [DATA_W-1:0]        snap_q;
    logic [LANES-1:0]         seen_q;
    logic [LANES-1:0]         lane_hit;
    logic [LANES-1:0]         seen_next;
    logic                     lane_ok;
    logic [BYTE_W-1:0]        src_lane [LANES];

    // Per-lane decode and source selection.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_hit[i] = (int'(addr) == i);
        assign src_lane[i] = (state_q == SNAP_HELD) ? snap_q[i*BYTE_W +: BYTE_W]
                                                    : live[i*BYTE_W +: BYTE_W];
    end

    assign lane_ok   = (int'(addr) < LANES);
    assign seen_next = seen_q | lane_hit;

    // Return the selected lane during a read, zero otherwise.
    always_comb begin
        rdata = '0;
        if (rd && lane_ok) begin
            rdata = src_lane[addr];
        end
    end

    // Snapshot capture, lane tracking and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SNAP_OPEN;
            seen_q  <= '0;
            snap_q  <= '0;
        end else if (rd && lane_ok) begin
            if (state_q == SNAP_OPEN) begin
                snap_q  <= live;
                seen_q  <= (&lane_hit) ? '0 : lane_hit;
                state_q <= (&lane_hit) ? SNAP_OPEN : SNAP_HELD;
            end else if (&seen_next) begin
                seen_q  <= '0;
                state_q <= SNAP_OPEN;
            end else begin
                seen_q  <= seen_next;
            end
        end
    end

    assign snap_o = snap_q;
    assign pend_o = (state_q == SNAP_HELD);

endmodule

// File: rtl/ccr_write_stage.sv
// Module: write staging path. Holds bytes written per lane and raises a
// commit strobe in the cycle the last unwritten lane is written. The
// merged word includes the byte being written in that cycle.
// Assumes: DATA_W is a multiple of BYTE_W.
module ccr_write_stage
    import ccr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int LANES = lane_count(DATA_W, BYTE_W),
    localparam int AW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [DATA_W-1:0] staged_o,
    output logic              commit_o
);

    logic [LANES-1:0]  seen_q;
    logic [LANES-1:0]  lane_hit;
    logic              lane_ok;
    logic              wr_ok;
    logic [BYTE_W-1:0] stage_q [LANES];

    assign lane_ok = (int'(addr) < LANES);
    assign wr_ok   = wr && lane_ok;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_hit[i] = (int'(addr) == i);

        // Merge the incoming byte over the stored one for this lane.
        assign staged_o[i*BYTE_W +: BYTE_W] = (wr_ok && lane_hit[i]) ? wdata : stage_q[i];

        // Store the byte written to this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[i] <= '0;
            end else if (wr_ok && lane_hit[i]) begin
                stage_q[i] <= wdata;
            end
        end
    end

    assign commit_o = wr_ok && (&(seen_q | lane_hit));

    // Track which lanes hold fresh bytes; clear on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (commit_o) begin
            seen_q <= '0;
        end else if (wr_ok) begin
            seen_q <= seen_q | lane_hit;
        end
    end

endmodule

// File: rtl/ccr_commit_reg.sv
// Module: committed value register. Loads the whole word on a single
// strobe, so the value seen by other logic always changes in one step.
// Assumes: load is a single-cycle strobe.
module ccr_commit_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);

    // Hold the committed word; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/coherent_reg16.sv
// Module: top of the coherent byte-access register. Joins the read
// snapshot path, the write staging path and the committed register.
// Assumes: a byte bus with simple strobes, and never a read and a write
// in the same cycle.
module coherent_reg16
    import ccr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int LANES = lane_count(DATA_W, BYTE_W),
    localparam int AW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] live_val,
    output logic [DATA_W-1:0] reg_val
);

    logic [DATA_W-1:0] snap_w;
    logic              pend_w;
    logic [DATA_W-1:0] staged_w;
    logic              commit_w;

    ccr_read_latch #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (bus_rd),
        .addr   (bus_addr),
        .live   (live_val),
        .rdata  (bus_rdata),
        .snap_o (snap_w),
        .pend_o (pend_w)
    );

    ccr_write_stage #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .staged_o (staged_w),
        .commit_o (commit_w)
    );

    ccr_commit_reg #(.DATA_W(DATA_W)) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .load (commit_w),
        .din  (staged_w),
        .q    (reg_val)
    );

endmodule

// File: rtl/ccr_checker.sv
// Module: assertion checker, bound into the top module.
// Assumes: it is attached through the bind statement below.
module ccr_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] live_val,
    input logic [DATA_W-1:0] reg_val,
    input logic [DATA_W-1:0] snap,
    input logic              pend,
    input logic [DATA_W-1:0] staged,
    input logic              commit
);

    // R1: a read with no snapshot pending captures the live word.
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !pend) |=> (snap == $past(live_val)));

    // R2: a pending snapshot does not move while no read happens.
    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !bus_rd) |=> ($stable(snap) && pend));

    // R5: without a commit the committed value holds.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(reg_val));

    // R6: a commit loads the full merged staged word.
    p_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (reg_val == $past(staged)));

    // R9: reset clears the committed value and the snapshot state.
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (reg_val == '0 && !pend));

    // Bus rule: a commit can only come from a write strobe.
    p_commit_needs_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (bus_wr && !bus_rd));

endmodule

bind coherent_reg16 ccr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .live_val(live_val),
    .reg_val (reg_val),
    .snap    (snap_w),
    .pend    (pend_w),
    .staged  (staged_w),
    .commit  (commit_w)
);

// File: tb/coherent_reg16_test.sv
// Bench: scoreboard-based test of the coherent byte-access register.
// Driver tasks push expected values; a negedge monitor pops and compares.
module coherent_reg16_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] live_val = '0;
    logic [15:0] reg_val;
    logic        chk_req = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [15:0] exp;
    } item_t;
    item_t sb_q[$];

    // Reference state derived from the requirements.
    logic [15:0] m_snap = '0;
    bit          m_pend = 1'b0;
    bit [1:0]    m_rseen = '0;
    logic [15:0] m_stage = '0;
    bit [1:0]    m_wseen = '0;
    logic [15:0] m_reg = '0;

    always #10 clk = ~clk;

    coherent_reg16 uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .live_val (live_val),
        .reg_val  (reg_val)
    );

    // Monitor: compare read data or the committed value against the queue.
    always @(negedge clk) begin
        if (rst_n && (bus_rd || chk_req)) begin
            logic [15:0] act;
            item_t it;
            act = bus_rd ? {8'h00, bus_rdata} : reg_val;
            n_cmp++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL %s: actual %h expected <none>", "scoreboard", act);
            end else begin
                it = sb_q.pop_front();
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; chk_req = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        m_snap = '0; m_pend = 1'b0; m_rseen = '0;
        m_stage = '0; m_wseen = '0; m_reg = '0;
    endtask

    task automatic set_live(input logic [15:0] v);
        @(posedge clk); #2;
        bus_rd = 1'b0; bus_wr = 1'b0; chk_req = 1'b0;
        live_val = v;
    endtask

    task automatic do_read(input bit a, input string tag);
        logic [15:0] src;
        bit [1:0] hit;
        @(posedge clk); #2;
        hit = a ? 2'b10 : 2'b01;
        src = m_pend ? m_snap : live_val;
        sb_q.push_back('{tag, {8'h00, a ? src[15:8] : src[7:0]}});
        if (!m_pend) begin
            m_snap = live_val; m_pend = 1'b1; m_rseen = hit;
        end else if ((m_rseen | hit) == 2'b11) begin
            m_pend = 1'b0; m_rseen = '0;
        end else begin
            m_rseen = m_rseen | hit;
        end
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0; chk_req = 1'b0;
    endtask

    task automatic do_write(input bit a, input logic [7:0] d);
        @(posedge clk); #2;
        if (a) m_stage[15:8] = d; else m_stage[7:0] = d;
        m_wseen = m_wseen | (a ? 2'b10 : 2'b01);
        if (m_wseen == 2'b11) begin
            m_reg = m_stage; m_wseen = '0;
        end
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0; chk_req = 1'b0;
    endtask

    task automatic check_reg(input string tag);
        @(posedge clk); #2;
        bus_rd = 1'b0; bus_wr = 1'b0; chk_req = 1'b1;
        sb_q.push_back('{tag, m_reg});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        check_reg("R9 reset value");

        // Low-first read with live change in between.
        set_live(16'hA1B2);
        do_read(1'b0, "R1 low from live");
        set_live(16'hC3D4);
        do_read(1'b1, "R2 high from snapshot");
        do_read(1'b0, "R3 fresh after pair");
        do_read(1'b1, "R7 high closes pair");

        // High-first read, repeated lane.
        set_live(16'h1234);
        do_read(1'b1, "R7 high first");
        set_live(16'h5678);
        do_read(1'b1, "R4 repeat high keeps snapshot");
        do_read(1'b0, "R2 low from snapshot");
        do_read(1'b0, "R3 fresh low");
        do_read(1'b1, "R2 high from new snapshot");

        // Low-first write pair.
        do_write(1'b0, 8'hAA);
        check_reg("R5 no commit after one byte");
        do_write(1'b1, 8'h55);
        check_reg("R6 commit both bytes");

        // High-first write with overwrite.
        do_write(1'b1, 8'h11);
        do_write(1'b1, 8'h22);
        check_reg("R8 repeat lane no commit");
        do_write(1'b0, 8'h33);
        check_reg("R8 overwritten byte committed");

        // Reads interleaved with a write pair.
        set_live(16'h9876);
        do_write(1'b0, 8'h44);
        do_read(1'b0, "R7 read between writes");
        check_reg("R5 staged during reads");
        do_write(1'b1, 8'h66);
        check_reg("R7 commit after interleave");
        do_read(1'b1, "R7 read pair completes");

        // Reset in the middle of both paths.
        set_live(16'h0F0F);
        do_read(1'b0, "R1 before reset");
        do_write(1'b0, 8'h77);
        do_reset();
        check_reg("R9 cleared by reset");
        do_write(1'b1, 8'h88);
        check_reg("R9 staging cleared");
        set_live(16'hABCD);
        do_read(1'b1, "R9 snapshot cleared");
        do_read(1'b0, "R2 low after reset pair");
        set_live(16'h0000);

        @(posedge clk); #2;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule